// File: doc/BRIEF.md
# Mode-Indexed Port Configuration Register Bank

This block stores the configuration registers of a set of 8-bit I/O ports. The registers cover direction, pullup enable, input level select, Schmitt enable and, on one port only, wakeup edge, wakeup enable, wakeup pending and comparator control. None of these registers has an address. A 5-bit mode register picks the register type that a port-control access reaches. The access itself gives only a port index and a W byte.

The low four mode bits give the register type. Mode bit 4 gives the direction: when it is 0 the selected register is copied into W, and when it is 1 W is copied into the selected register. Two groups of wake registers ignore bit 4. The comparator and pending registers always swap with W, and the edge and enable registers always take W.

The mode is loaded either from a 4-bit literal, which leaves bit 4 alone, or from W. A setting stays in force until the next load, so one mode load followed by one access per port configures the same register type on every port. The contents of every register are driven out continuously.

Top module: `port_cfg_bank`

## Requirements
- R1: On synchronous reset the mode is 0x1F, every direction register is 0xFF (all inputs), and every other configuration register is 0x00.
- R2: `mode_lit_ld` replaces mode bits 3:0 with `mode_lit` from the next cycle and keeps mode bit 4 unchanged.
- R3: `mode_w_ld` loads `w_in[4:0]` into the whole mode from the next cycle. If both loads occur in the same cycle, the W load wins. A port access always uses the mode as it was before that cycle's load. The mode holds its value until it is loaded again.
- R4: A `mode_rd` strobe with no access in the same cycle drives `w_vld`=1 and `w_out` = {3'b000, mode} in that cycle.
- R5: The common codes are 0xF direction, 0xE pullup, 0xD level and 0xC Schmitt. With mode bit 4 = 0, an access to one of these codes drives `w_vld`=1 and sets `w_out` to the selected register of port `acc_port` in the same cycle, and it changes no register.
- R6: With mode bit 4 = 1, an access to a common code writes `w_in` into the selected register from the next cycle and drives `w_vld`=0.
- R7: On port index 1 (port B), code 0x8 (comparator) and code 0x9 (wakeup pending) swap, whatever mode bit 4 is. In the access cycle `w_out` shows the old value with `w_vld`=1, and from the next cycle the register holds `w_in`.
- R8: On port index 1, code 0xB (wakeup edge) and code 0xA (wakeup enable) always write `w_in`, whatever mode bit 4 is, and drive `w_vld`=0.
- R9: An access is rejected in any of these cases: mode bits 3:0 below 0x8, codes 0x8 to 0xB on a port other than 1, code 0xC on port 0, or `acc_port` of 5 or more. A rejected access changes no register and drives `w_vld`=1 with `w_out`=0.
- R10: After a W load of 0x1E, five write accesses to ports 0 to 4 set all five pullup registers. Port p is driven on bits [8p+7:8p] of each per-port output bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_lit_ld | input | 1 | Load literal into mode bits 3:0 |
| mode_lit | input | 4 | Literal for mode low bits |
| mode_w_ld | input | 1 | Load w_in[4:0] into mode |
| mode_rd | input | 1 | Return mode on w_out |
| acc_en | input | 1 | Port-control access strobe |
| acc_port | input | 3 | Port index of the access |
| w_in | input | 8 | W data byte |
| w_out | output | 8 | Data returned to W |
| w_vld | output | 1 | w_out carries a result this cycle |
| dir_o | output | 40 | Direction registers, port p at [8p+7:8p] |
| pull_o | output | 40 | Pullup enable registers |
| lvl_o | output | 40 | Input level select registers |
| schm_o | output | 40 | Schmitt enable registers (port 0 slice stays 0) |
| wk_edge_o | output | 8 | Port B wakeup edge register |
| wk_en_o | output | 8 | Port B wakeup enable register |
| wk_pnd_o | output | 8 | Port B wakeup pending register |
| cmp_o | output | 8 | Port B comparator register |

## Verification
The bench builds the block with its default parameters. There are five ports, the wake group is on port 1, and port 0 has no Schmitt register. With five ports, the 3-bit port index has spare values 5 to 7, so out-of-range rejection can be exercised alongside the reserved codes and the missing-register cases. Because the wake group sits on port 1 rather than port 0, the bench can tell a port-B-only code that is correctly decoded apart from one that leaks onto other ports. The expected W results go through a scoreboard queue in step with every access and mode read.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned MODE_W = 5;
    localparam logic [MODE_W-1:0] MODE_RESET = 5'h1F;

    typedef enum logic [3:0] {
        K_CMP     = 4'h8,
        K_WKPND   = 4'h9,
        K_WKEN    = 4'hA,
        K_WKEDGE  = 4'hB,
        K_SCHMITT = 4'hC,
        K_LEVEL   = 4'hD,
        K_PULL    = 4'hE,
        K_DIR     = 4'hF
    } reg_kind_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_SWAP,
        OP_BAD
    } acc_op_e;

    typedef struct packed {
        acc_op_e    op;
        logic [3:0] kind;
    } acc_dec_t;

    function automatic logic is_wake_code(input logic [3:0] code);
        return code[3:2] == 2'b10;
    endfunction

    function automatic logic is_common_code(input logic [3:0] code);
        return code[3:2] == 2'b11;
    endfunction
endpackage

// File: rtl/pcfg_mode_reg.sv
module pcfg_mode_reg
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lit_ld,
    input  logic [3:0]        lit,
    input  logic              w_ld,
    input  logic [MODE_W-1:0] w_val,
    output logic [MODE_W-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else if (w_ld) begin
            mode_q <= w_val;
        end else if (lit_ld) begin
            mode_q <= {mode_q[MODE_W-1], lit};
        end
    end
endmodule

// File: rtl/pcfg_decode.sv
module pcfg_decode
    import pcfg_pkg::*;
#(
    parameter int NUM_PORTS       = 5,
    parameter int PIDX_W          = 3,
    parameter int WAKE_PORT       = 1,
    parameter int NO_SCHMITT_PORT = 0
) (
    input  logic              acc_en,
    input  logic [MODE_W-1:0] mode,
    input  logic [PIDX_W-1:0] port,
    output acc_dec_t          dec
);
    logic [3:0] code;
    logic       port_ok;

    assign code    = mode[3:0];
    assign port_ok = 32'(port) < NUM_PORTS;

    always_comb begin
        dec.kind = code;
        dec.op   = OP_NONE;
        if (acc_en) begin
            if (!port_ok || !code[3]) begin
                dec.op = OP_BAD;
            end else if (is_wake_code(code)) begin
                if (port != PIDX_W'(WAKE_PORT)) begin
                    dec.op = OP_BAD;
                end else if (code[1]) begin
                    dec.op = OP_WRITE;
                end else begin
                    dec.op = OP_SWAP;
                end
            end else if (code == K_SCHMITT && port == PIDX_W'(NO_SCHMITT_PORT)) begin
                dec.op = OP_BAD;
            end else begin
                dec.op = mode[4] ? OP_WRITE : OP_READ;
            end
        end
    end
endmodule

// File: rtl/pcfg_port_regs.sv
module pcfg_port_regs
    import pcfg_pkg::*;
#(
    parameter bit HAS_SCHMITT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        kind,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] dir_q,
    output logic [BYTE_W-1:0] pull_q,
    output logic [BYTE_W-1:0] lvl_q,
    output logic [BYTE_W-1:0] schm_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            pull_q <= '0;
            lvl_q  <= '0;
        end else if (wr_en) begin
            if (kind == K_DIR)   dir_q  <= wr_data;
            if (kind == K_PULL)  pull_q <= wr_data;
            if (kind == K_LEVEL) lvl_q  <= wr_data;
        end
    end

    generate
        if (HAS_SCHMITT) begin : g_schm
            always_ff @(posedge clk) begin
                if (rst) begin
                    schm_q <= '0;
                end else if (wr_en && kind == K_SCHMITT) begin
                    schm_q <= wr_data;
                end
            end
        end else begin : g_no_schm
            assign schm_q = '0;
        end
    endgenerate

    always_comb begin
        case (kind)
            K_DIR:     rd_data = dir_q;
            K_PULL:    rd_data = pull_q;
            K_LEVEL:   rd_data = lvl_q;
            K_SCHMITT: rd_data = schm_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pcfg_wake_regs.sv
module pcfg_wake_regs
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        kind,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] edge_q,
    output logic [BYTE_W-1:0] en_q,
    output logic [BYTE_W-1:0] pnd_q,
    output logic [BYTE_W-1:0] cmp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            en_q   <= '0;
            pnd_q  <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            if (kind == K_WKEDGE) edge_q <= wr_data;
            if (kind == K_WKEN)   en_q   <= wr_data;
            if (kind == K_WKPND)  pnd_q  <= wr_data;
            if (kind == K_CMP)    cmp_q  <= wr_data;
        end
    end

    always_comb begin
        case (kind)
            K_WKPND: rd_data = pnd_q;
            K_CMP:   rd_data = cmp_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/port_cfg_bank.sv
module port_cfg_bank
    import pcfg_pkg::*;
#(
    parameter int NUM_PORTS       = 5,
    parameter int PIDX_W          = 3,
    parameter int WAKE_PORT       = 1,
    parameter int NO_SCHMITT_PORT = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode_lit_ld,
    input  logic [3:0]                    mode_lit,
    input  logic                          mode_w_ld,
    input  logic                          mode_rd,
    input  logic                          acc_en,
    input  logic [PIDX_W-1:0]             acc_port,
    input  logic [BYTE_W-1:0]             w_in,
    output logic [BYTE_W-1:0]             w_out,
    output logic                          w_vld,
    output logic [NUM_PORTS*BYTE_W-1:0]   dir_o,
    output logic [NUM_PORTS*BYTE_W-1:0]   pull_o,
    output logic [NUM_PORTS*BYTE_W-1:0]   lvl_o,
    output logic [NUM_PORTS*BYTE_W-1:0]   schm_o,
    output logic [BYTE_W-1:0]             wk_edge_o,
    output logic [BYTE_W-1:0]             wk_en_o,
    output logic [BYTE_W-1:0]             wk_pnd_o,
    output logic [BYTE_W-1:0]             cmp_o
);
    logic [MODE_W-1:0] mode_q;
    acc_dec_t          dec;
    logic              store;
    logic [BYTE_W-1:0] port_rd [NUM_PORTS];
    logic [BYTE_W-1:0] wake_rd;
    logic [BYTE_W-1:0] sel_rd;

    pcfg_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .lit_ld (mode_lit_ld),
        .lit    (mode_lit),
        .w_ld   (mode_w_ld),
        .w_val  (w_in[MODE_W-1:0]),
        .mode_q (mode_q)
    );

    pcfg_decode #(
        .NUM_PORTS       (NUM_PORTS),
        .PIDX_W          (PIDX_W),
        .WAKE_PORT       (WAKE_PORT),
        .NO_SCHMITT_PORT (NO_SCHMITT_PORT)
    ) u_dec (
        .acc_en (acc_en),
        .mode   (mode_q),
        .port   (acc_port),
        .dec    (dec)
    );

    assign store = (dec.op == OP_WRITE) || (dec.op == OP_SWAP);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            pcfg_port_regs #(
                .HAS_SCHMITT (p != NO_SCHMITT_PORT)
            ) u_regs (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (store && is_common_code(dec.kind) && acc_port == PIDX_W'(p)),
                .kind    (dec.kind),
                .wr_data (w_in),
                .rd_data (port_rd[p]),
                .dir_q   (dir_o [p*BYTE_W +: BYTE_W]),
                .pull_q  (pull_o[p*BYTE_W +: BYTE_W]),
                .lvl_q   (lvl_o [p*BYTE_W +: BYTE_W]),
                .schm_q  (schm_o[p*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    pcfg_wake_regs u_wake (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store && is_wake_code(dec.kind)),
        .kind    (dec.kind),
        .wr_data (w_in),
        .rd_data (wake_rd),
        .edge_q  (wk_edge_o),
        .en_q    (wk_en_o),
        .pnd_q   (wk_pnd_o),
        .cmp_q   (cmp_o)
    );

    always_comb begin
        sel_rd = '0;
        if (is_wake_code(dec.kind)) begin
            sel_rd = wake_rd;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (acc_port == PIDX_W'(p)) sel_rd = port_rd[p];
            end
        end
    end

    always_comb begin
        w_out = '0;
        w_vld = 1'b0;
        case (dec.op)
            OP_READ, OP_SWAP: begin
                w_vld = 1'b1;
                w_out = sel_rd;
            end
            OP_BAD: w_vld = 1'b1;
            OP_WRITE: w_vld = 1'b0;
            default: begin
                if (mode_rd) begin
                    w_vld = 1'b1;
                    w_out = BYTE_W'(mode_q);
                end
            end
        endcase
    end
endmodule

// File: rtl/pcfg_checker.sv
module pcfg_checker
    import pcfg_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PIDX_W    = 3,
    parameter int WAKE_PORT = 1,
    parameter int CFG_W     = 4 * NUM_PORTS * BYTE_W + 4 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_lit_ld,
    input logic [3:0]        mode_lit,
    input logic              mode_w_ld,
    input logic              acc_en,
    input logic [PIDX_W-1:0] acc_port,
    input logic [BYTE_W-1:0] w_in,
    input logic [BYTE_W-1:0] w_out,
    input logic              w_vld,
    input logic [MODE_W-1:0] mode_q,
    input logic [CFG_W-1:0]  cfg_all,
    input logic [BYTE_W-1:0] cmp_b,
    input logic [BYTE_W-1:0] edge_b
);
    logic on_wake;
    assign on_wake = acc_en && acc_port == PIDX_W'(WAKE_PORT);

    a_r2_lit_keeps_top: assert property (@(posedge clk) disable iff (rst)
        mode_lit_ld && !mode_w_ld |=> mode_q == {$past(mode_q[4]), $past(mode_lit)});

    a_r3_w_load: assert property (@(posedge clk) disable iff (rst)
        mode_w_ld |=> mode_q == $past(w_in[MODE_W-1:0]));

    a_r5_read_no_change: assert property (@(posedge clk) disable iff (rst)
        acc_en && !mode_q[4] && mode_q[3:2] == 2'b11 |=> $stable(cfg_all));

    a_r7_cmp_old_out: assert property (@(posedge clk) disable iff (rst)
        on_wake && mode_q[3:0] == 4'h8 |-> w_vld && w_out == cmp_b);

    a_r7_cmp_takes_w: assert property (@(posedge clk) disable iff (rst)
        on_wake && mode_q[3:0] == 4'h8 |=> cmp_b == $past(w_in));

    a_r8_edge_write: assert property (@(posedge clk) disable iff (rst)
        on_wake && mode_q[3:0] == 4'hB |=> edge_b == $past(w_in));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        acc_en && !mode_q[3] |-> w_vld && w_out == '0);

    a_r9_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        acc_en && !mode_q[3] |=> $stable(cfg_all));
endmodule

bind port_cfg_bank pcfg_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PIDX_W    (PIDX_W),
    .WAKE_PORT (WAKE_PORT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_lit_ld (mode_lit_ld),
    .mode_lit    (mode_lit),
    .mode_w_ld   (mode_w_ld),
    .acc_en      (acc_en),
    .acc_port    (acc_port),
    .w_in        (w_in),
    .w_out       (w_out),
    .w_vld       (w_vld),
    .mode_q      (mode_q),
    .cfg_all     ({dir_o, pull_o, lvl_o, schm_o, wk_edge_o, wk_en_o, wk_pnd_o, cmp_o}),
    .cmp_b       (cmp_o),
    .edge_b      (wk_edge_o)
);

// File: tb/port_cfg_bank_tb.sv
`timescale 1ns/1ps
module port_cfg_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_lit_ld = 1'b0;
    logic [3:0]  mode_lit = '0;
    logic        mode_w_ld = 1'b0;
    logic        mode_rd = 1'b0;
    logic        acc_en = 1'b0;
    logic [2:0]  acc_port = '0;
    logic [7:0]  w_in = '0;
    logic [7:0]  w_out;
    logic        w_vld;
    logic [39:0] dir_o, pull_o, lvl_o, schm_o;
    logic [7:0]  wk_edge_o, wk_en_o, wk_pnd_o, cmp_o;

    int total = 0;
    int bad   = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    port_cfg_bank u_dut (
        .clk(clk), .rst(rst), .mode_lit_ld(mode_lit_ld), .mode_lit(mode_lit),
        .mode_w_ld(mode_w_ld), .mode_rd(mode_rd), .acc_en(acc_en),
        .acc_port(acc_port), .w_in(w_in), .w_out(w_out), .w_vld(w_vld),
        .dir_o(dir_o), .pull_o(pull_o), .lvl_o(lvl_o), .schm_o(schm_o),
        .wk_edge_o(wk_edge_o), .wk_en_o(wk_en_o), .wk_pnd_o(wk_pnd_o), .cmp_o(cmp_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected W result per access or mode read
    always @(negedge clk) begin
        if (!rst && (acc_en || mode_rd)) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", {55'd0, w_vld, w_out}, 64'h1FF);
            end else begin
                chk(tag_q.pop_front(), {55'd0, w_vld, w_out}, {55'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic acc(input int port, input logic [7:0] w, input logic ev,
                       input logic [7:0] ew, input string tag);
        @(posedge clk); #1;
        acc_en = 1'b1; acc_port = 3'(port); w_in = w;
        exp_q.push_back({ev, ew}); tag_q.push_back(tag);
        @(posedge clk); #1;
        acc_en = 1'b0;
    endtask

    task automatic load_w(input logic [4:0] m);
        @(posedge clk); #1;
        mode_w_ld = 1'b1; w_in = {3'b000, m};
        @(posedge clk); #1;
        mode_w_ld = 1'b0;
    endtask

    task automatic load_lit(input logic [3:0] m);
        @(posedge clk); #1;
        mode_lit_ld = 1'b1; mode_lit = m;
        @(posedge clk); #1;
        mode_lit_ld = 1'b0;
    endtask

    task automatic rd_mode(input logic [4:0] em, input string tag);
        @(posedge clk); #1;
        mode_rd = 1'b1;
        exp_q.push_back({1'b1, 3'b000, em}); tag_q.push_back(tag);
        @(posedge clk); #1;
        mode_rd = 1'b0;
    endtask

    task automatic look(input string tag, input logic [63:0] act, input logic [63:0] exp);
        @(negedge clk);
        chk(tag, act, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [191:0] snap;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;

        // R1 reset state
        look("R1 dir reset", 64'(dir_o), 64'hFF_FFFF_FFFF);
        look("R1 others reset", 64'(pull_o | lvl_o | schm_o), 64'h0);
        look("R1 wake reset", {32'd0, wk_edge_o, wk_en_o, wk_pnd_o, cmp_o}, 64'h0);
        rd_mode(5'h1F, "R1 R4 mode reset read");

        // R10 pullups on all ports with one mode load
        load_w(5'h1E);
        for (int p = 0; p < 5; p++) acc(p, 8'h10 + 8'(p), 1'b0, 8'h00, "R10 R6 pull write");
        look("R10 pullups", 64'(pull_o), 64'h14_1312_1110);
        rd_mode(5'h1E, "R3 mode persists");

        // R2 literal load keeps bit 4
        load_lit(4'hD);
        rd_mode(5'h1D, "R2 literal keeps bit4=1");
        acc(2, 8'h5A, 1'b0, 8'h00, "R6 level write");
        look("R6 level port2", 64'(lvl_o), 64'h00_005A_0000);

        // R3 W load clears bit 4, then R5 reads
        load_w(5'h0D);
        rd_mode(5'h0D, "R3 w load");
        acc(2, 8'hEE, 1'b1, 8'h5A, "R5 read level port2");
        look("R5 level unchanged", 64'(lvl_o), 64'h00_005A_0000);
        load_lit(4'hE);
        rd_mode(5'h0E, "R2 literal keeps bit4=0");
        acc(3, 8'h00, 1'b1, 8'h13, "R5 read pull port3");
        load_lit(4'hF);
        acc(0, 8'h00, 1'b1, 8'hFF, "R5 read dir port0");
        look("R5 dir unchanged", 64'(dir_o), 64'hFF_FFFF_FFFF);

        // R7 swaps, bit4 = 0 and bit4 = 1
        load_lit(4'h8);
        acc(1, 8'h3C, 1'b1, 8'h00, "R7 cmp swap first");
        acc(1, 8'h11, 1'b1, 8'h3C, "R7 cmp swap second");
        look("R7 cmp holds w", 64'(cmp_o), 64'h11);
        load_w(5'h19);
        acc(1, 8'hC3, 1'b1, 8'h00, "R7 pending swap bit4=1");
        look("R7 pending holds w", 64'(wk_pnd_o), 64'hC3);

        // R8 always-write group with bit4 = 0
        load_w(5'h0B);
        acc(1, 8'hA5, 1'b0, 8'h00, "R8 edge write");
        look("R8 edge", 64'(wk_edge_o), 64'hA5);
        load_lit(4'hA);
        acc(1, 8'h66, 1'b0, 8'h00, "R8 enable write");
        look("R8 enable", 64'(wk_en_o), 64'h66);

        // R6 Schmitt on a port that has one
        load_w(5'h1C);
        acc(4, 8'h77, 1'b0, 8'h00, "R6 schmitt port4");
        look("R6 schmitt port4", 64'(schm_o), 64'h77_0000_0000);

        // R9 rejected accesses
        @(negedge clk);
        snap = {dir_o, pull_o, lvl_o, schm_o, wk_edge_o, wk_en_o, wk_pnd_o, cmp_o};
        acc(0, 8'h99, 1'b1, 8'h00, "R9 schmitt on port0");
        load_w(5'h1B);
        acc(3, 8'h99, 1'b1, 8'h00, "R9 wake code on port3");
        load_w(5'h15);
        acc(2, 8'h99, 1'b1, 8'h00, "R9 reserved code");
        load_w(5'h1F);
        acc(6, 8'h99, 1'b1, 8'h00, "R9 port out of range");
        look("R9 nothing changed",
             64'({dir_o, pull_o, lvl_o, schm_o, wk_edge_o, wk_en_o, wk_pnd_o, cmp_o} != snap), 64'h0);

        // R3 both loads together: W load wins
        @(posedge clk); #1;
        mode_lit_ld = 1'b1; mode_lit = 4'h2; mode_w_ld = 1'b1; w_in = 8'h0E;
        @(posedge clk); #1;
        mode_lit_ld = 1'b0; mode_w_ld = 1'b0;
        rd_mode(5'h0E, "R3 w load wins");

        repeat (3) @(posedge clk);
        chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule